// File: doc/BRIEF.md
# Switched-Capacitor Serial DAC Sequencer

This block is the digital controller for a charge-sharing serial DAC built from two equal capacitors. One is the working capacitor. The other is the holding capacitor. A code of `WIDTH` bits is handed over with a start/ready handshake. The block first empties the holding capacitor. It then walks through the code one bit at a time, least significant bit first.

Every bit takes two active half-cycles:
- In the load half-cycle, the working capacitor is charged to the reference or drained to zero, according to the bit.
- In the share half-cycle, the two capacitors are joined so that their charge splits evenly.

After the most significant bit, a single sample phase puts the downstream track-and-hold into track mode. The track-and-hold then returns to hold and a completion pulse is raised.

Consecutive changes of the switch enables are always separated by one clock with every enable low. This is the break-before-make rule. Alongside the switch control, the block keeps an exact fixed-point model of the holding-capacitor voltage, as a fraction of the reference. This model lets a bench confirm the conversion arithmetic.

Top module: `scdac_seq`

## Requirements
- R1: The first clock after a start is accepted (cycle 1) drives `sw_clear` high for exactly one clock. `model_frac` reads 0 from the following cycle (cycle 2).
- R2: Bits are processed least significant bit first. The load phase of bit k (k = 0 for the LSB) falls in cycle 3+4k after the accepting edge.
- R3: In a load phase, `sw_charge` is high when the bit is 1, and `sw_drain` is high when the bit is 0. Only one of them is high, for one clock.
- R4: Two clocks after each load phase, `sw_share` is high alone for one clock.
- R5: `model_frac` is an unsigned value scaled by 2^(WIDTH+2). After each share phase it becomes (v + d·2^(WIDTH+2))/2, where d is the bit just shared. At completion it equals the code shifted left by two.
- R6: At most one of `sw_clear`, `sw_charge`, `sw_drain`, `sw_share` and `sh_track` is high in any cycle. Every cycle in which one of them is high is followed by a cycle in which all of them are low.
- R7: `sh_track` is high for exactly one clock, in cycle 3+4·WIDTH after the accepting edge. It is low at all other times.
- R8: `ready` is the inverse of `busy`. `start` is accepted only while `ready` is high. Starts raised during a conversion, and changes of `code_in` during a conversion, have no effect on the switch sequence or on `model_frac`.
- R9: `done` is high for one clock, in cycle 4+4·WIDTH, with `busy` low in that cycle. `model_frac` does not change while the block is idle.
- R10: While `rst_n` is low, and after it is released, all switch enables, `sh_track`, `done` and `busy` are low, `ready` is high and `model_frac` is 0.
- R11: A conversion contains exactly 2·WIDTH charge, drain or share phases. A start held high in the `done` cycle is accepted at once, with the code present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to convert `code_in` |
| code_in | input | WIDTH | Code to convert, captured when start is accepted |
| ready | output | 1 | High when a start will be accepted |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when the track-and-hold enters hold |
| sw_clear | output | 1 | Closes the switch that empties the holding capacitor |
| sw_charge | output | 1 | Connects the working capacitor to the reference |
| sw_drain | output | 1 | Connects the working capacitor to ground |
| sw_share | output | 1 | Joins the working and holding capacitors |
| sh_track | output | 1 | High: track-and-hold tracks; low: it holds |
| model_frac | output | WIDTH+2 | Model of holding-capacitor voltage, scaled by 2^(WIDTH+2) |

## Verification
Several properties are checked on every cycle:
- mutual exclusion of the five enables and the idle gap after each one;
- the fixed spacing from a load phase to its share phase;
- the halving update of the model at each share;
- the clearing of the model after the clear phase;
- the ordering of track, done and idle.

The scenarios show what the assertions cannot:
- that the bits appear least significant first;
- that the final model equals the captured code;
- that starts and code changes arriving mid-conversion are ignored;
- that a start held through the done cycle chains a new conversion without a gap.

// File: rtl/scdac_pkg.sv
package scdac_pkg;

  // Phase of the sequencer; every active phase is followed by a gap phase.
  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_CLEAR     = 3'd1,
    PH_GAP_CLR   = 3'd2,
    PH_LOAD      = 3'd3,
    PH_GAP_LOAD  = 3'd4,
    PH_SHARE     = 3'd5,
    PH_GAP_SHARE = 3'd6,
    PH_SAMPLE    = 3'd7
  } phase_t;

endpackage

// File: rtl/scdac_phase_fsm.sv
module scdac_phase_fsm
  import scdac_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   accept,
  output logic   bit_step,
  output logic   busy,
  output logic   done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  logic [CW-1:0] bits_done;

  assign busy     = (phase != PH_IDLE);
  assign accept   = (phase == PH_IDLE) && start;
  assign bit_step = (phase == PH_SHARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bits_done <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_CLEAR;
            bits_done <= '0;
          end
        end
        PH_CLEAR:    phase <= PH_GAP_CLR;
        PH_GAP_CLR:  phase <= PH_LOAD;
        PH_LOAD:     phase <= PH_GAP_LOAD;
        PH_GAP_LOAD: phase <= PH_SHARE;
        PH_SHARE: begin
          phase     <= PH_GAP_SHARE;
          bits_done <= bits_done + 1'b1;
        end
        PH_GAP_SHARE: begin
          if (bits_done == LAST) phase <= PH_SAMPLE;
          else                   phase <= PH_LOAD;
        end
        PH_SAMPLE: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scdac_shifter.sv
module scdac_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] code,
  output logic             lsb
);

  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= code;
    else if (shift) sr <= sr >> 1;
  end

  assign lsb = sr[0];

endmodule

// File: rtl/scdac_charge_model.sv
module scdac_charge_model #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              bit_in,
  output logic [WIDTH+1:0]  value
);

  localparam int FW = WIDTH + 2;

  // Charge sharing between equal capacitors: average of the held value
  // and the working capacitor (full scale or zero).
  function automatic logic [FW-1:0] share_step(input logic [FW-1:0] v,
                                                input logic d);
    logic [FW:0] sum;
    sum = {1'b0, v} + {d, {FW{1'b0}}};
    return sum[FW:1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clear) value <= '0;
    else if (step)  value <= share_step(value, bit_in);
  end

endmodule

// File: rtl/scdac_seq.sv
module scdac_seq
  import scdac_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] code_in,
  output logic             ready,
  output logic             busy,
  output logic             done,
  output logic             sw_clear,
  output logic             sw_charge,
  output logic             sw_drain,
  output logic             sw_share,
  output logic             sh_track,
  output logic [WIDTH+1:0] model_frac
);

  phase_t phase;
  logic   accept;
  logic   bit_step;
  logic   cur_bit;

  scdac_phase_fsm #(.WIDTH(WIDTH)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .phase    (phase),
    .accept   (accept),
    .bit_step (bit_step),
    .busy     (busy),
    .done     (done)
  );

  scdac_shifter #(.WIDTH(WIDTH)) u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (bit_step),
    .code  (code_in),
    .lsb   (cur_bit)
  );

  scdac_charge_model #(.WIDTH(WIDTH)) u_model (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (sw_clear),
    .step   (bit_step),
    .bit_in (cur_bit),
    .value  (model_frac)
  );

  assign ready     = !busy;
  assign sw_clear  = (phase == PH_CLEAR);
  assign sw_charge = (phase == PH_LOAD) &&  cur_bit;
  assign sw_drain  = (phase == PH_LOAD) && !cur_bit;
  assign sw_share  = (phase == PH_SHARE);
  assign sh_track  = (phase == PH_SAMPLE);

endmodule

// File: rtl/scdac_seq_chk.sv
module scdac_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             busy,
  input logic             done,
  input logic             sw_clear,
  input logic             sw_charge,
  input logic             sw_drain,
  input logic             sw_share,
  input logic             sh_track,
  input logic             cur_bit,
  input logic [WIDTH+1:0] model_frac
);

  localparam int FW = WIDTH + 2;

  logic [4:0] enables;
  assign enables = {sw_clear, sw_charge, sw_drain, sw_share, sh_track};

  p_one_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(enables) <= 1);

  p_gap_after_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enables != 5'd0) |=> (enables == 5'd0));

  p_clear_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sw_clear);

  p_model_zeroed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (model_frac == '0));

  p_load_then_share_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_charge || sw_drain) |-> ##2 sw_share);

  p_share_halves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_share |=> ({model_frac, 1'b0} ==
                  ({1'b0, $past(model_frac)} + {$past(cur_bit), {FW{1'b0}}})));

  p_ready_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready == !busy);

  p_track_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sh_track |=> (done && !busy));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(model_frac));

endmodule

bind scdac_seq scdac_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .busy       (busy),
  .done       (done),
  .sw_clear   (sw_clear),
  .sw_charge  (sw_charge),
  .sw_drain   (sw_drain),
  .sw_share   (sw_share),
  .sh_track   (sh_track),
  .cur_bit    (cur_bit),
  .model_frac (model_frac)
);

// File: tb/scdac_seq_test.sv
module scdac_seq_test;

  localparam int N    = 8;
  localparam int LAST = 4 + 4 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] code_in = '0;
  logic         ready, busy, done;
  logic         sw_clear, sw_charge, sw_drain, sw_share, sh_track;
  logic [N+1:0] model_frac;

  int checks = 0;
  int bad = 0;

  // reference state
  int t = -1;
  int cur_code = 0;
  int v_exp = 0;
  int quanta = 0;

  always #10 clk = ~clk;

  scdac_seq #(.WIDTH(N)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .code_in    (code_in),
    .ready      (ready),
    .busy       (busy),
    .done       (done),
    .sw_clear   (sw_clear),
    .sw_charge  (sw_charge),
    .sw_drain   (sw_drain),
    .sw_share   (sw_share),
    .sh_track   (sh_track),
    .model_frac (model_frac)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0d)",
               req, what, act, exp, t);
    end
  endtask

  // Behavioural reference: cycle index since the accepting edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1;
      v_exp = 0;
    end else begin
      if ((t < 0 || t == LAST) && start) begin
        t = 1;
        cur_code = int'(code_in);
      end else if (t == LAST) begin
        t = -1;
      end else if (t > 0) begin
        t++;
      end
      if (t >= 2) begin
        int j;
        j = (t < 6) ? 0 : ((t - 6) / 4 + 1);
        if (j > N) j = N;
        v_exp = (cur_code % (1 << j)) << (N + 2 - j);
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_load, e_share, e_bit;
      int ph;
      ph = t - 3;
      e_load  = (t >= 3) && (t < 3 + 4 * N) && (ph % 4 == 0);
      e_share = (t >= 3) && (t < 3 + 4 * N) && (ph % 4 == 2);
      e_bit   = e_load ? ((cur_code >> (ph / 4)) & 1) : 1'b0;
      chk("R1", "sw_clear", int'(sw_clear), int'(t == 1));
      chk("R2/R3", "sw_charge", int'(sw_charge), int'(e_load && e_bit));
      chk("R2/R3", "sw_drain", int'(sw_drain), int'(e_load && !e_bit));
      chk("R4", "sw_share", int'(sw_share), int'(e_share));
      chk("R7", "sh_track", int'(sh_track), int'(t == 3 + 4 * N));
      chk("R8", "busy", int'(busy), int'(t >= 1 && t <= 3 + 4 * N));
      chk("R8", "ready", int'(ready), int'(!(t >= 1 && t <= 3 + 4 * N)));
      chk("R9", "done", int'(done), int'(t == LAST));
      chk("R5", "model_frac", int'(model_frac), v_exp);
      chk("R6", "enable count",
          $countones({sw_clear, sw_charge, sw_drain, sw_share, sh_track}),
          (t == 1 || e_load || e_share || t == 3 + 4 * N) ? 1 : 0);
      if (sw_clear) quanta = 0;
      if (sw_charge || sw_drain || sw_share) quanta++;
      if (done) begin
        chk("R11", "switching quanta", quanta, 2 * N);
        chk("R5", "final model vs code<<2", int'(model_frac), cur_code * 4);
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic convert(input logic [N-1:0] c);
    @(negedge clk);
    start   = 1'b1;
    code_in = c;
    @(negedge clk);
    start   = 1'b0;
    code_in = ~c;
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R10: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", int'(busy), 0);
    chk("R10", "ready in reset", int'(ready), 1);
    chk("R10", "enables in reset",
        int'({sw_clear, sw_charge, sw_drain, sw_share, sh_track}), 0);
    chk("R10", "model in reset", int'(model_frac), 0);
    chk("R10", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "idle after reset", int'({busy, done, sh_track}), 0);

    // R2 R3 R5: assorted codes, including the extremes
    convert(8'h00);
    convert(8'hFF);
    convert(8'h01);
    convert(8'h80);
    convert(8'hA5);
    repeat (3) @(negedge clk);
    // R9: model unchanged while idle
    chk("R9", "idle model", int'(model_frac), 8'hA5 * 4);

    // R8: a start and new codes during a conversion are ignored
    @(negedge clk);
    start = 1'b1; code_in = 8'h5A;
    @(negedge clk);
    start = 1'b0; code_in = 8'hFF;
    repeat (7) @(negedge clk);
    start = 1'b1; code_in = 8'h0F;
    @(negedge clk);
    start = 1'b0; code_in = 8'h33;
    wait_done();
    chk("R8", "ignored mid-run start", int'(model_frac), 8'h5A * 4);

    // R11: start held through the done cycle chains a new conversion
    @(negedge clk);
    start = 1'b1; code_in = 8'h3C;
    wait_done();
    code_in = 8'hC3;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "chained start accepted", int'(sw_clear), 1);
    wait_done();
    chk("R11", "chained code", int'(model_frac), 8'hC3 * 4);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule